// File: doc/BRIEF.md
# Bus Idle Timeout Monitor

This block watches the clock line of a shared two-wire bus and tells a local master whether the bus is free. The clock line is brought into the core clock domain through a two-flop synchronizer. Every rising or falling transition on the synchronized clock line restarts an inactivity counter. The bus is treated as busy while clock transitions keep arriving. It is treated as idle once the counter reaches a programmable timeout with no transition in between. START and STOP conditions are not decoded.

A local master that wants the bus raises a request. The monitor grants it in the same cycle, but only if the bus is idle and no clock transition is being seen in that cycle. A grant marks the bus busy and restarts the counter. A one-cycle strobe marks each return to idle. The timeout is 16 bits wide so that masters with very different clock rates can share the bus.

Top module: `bus_idle_monitor`

## Requirements
- R1: Each transition of scl_i, rising or falling, restarts the inactivity count and forces the busy state. The transition acts at the third rising clock edge after scl_i changes, because of the two synchronizer stages.
- R2: With no restart, busy_o falls at exactly the timeout_i-th rising edge after the edge at which the last restart took effect.
- R3: A timeout_i value of 0 gives a timeout of 65536 cycles.
- R4: While rst_ni is low, busy_o is 1, idle_entry_o is 0 and acq_grant_o is 0. With no clock activity, busy_o falls at the timeout_i-th rising edge after reset is released.
- R5: idle_entry_o is high for exactly one cycle, in the cycle in which busy_o first reads 0 after being 1, and it is low at all other times.
- R6: While idle, busy_o stays 0 until a clock transition or a grant occurs. A clock transition seen while idle sets busy_o.
- R7: acq_grant_o is combinational and is 1 exactly when acq_req_i is 1, busy_o is 0, and no synchronized clock transition is detected in the same cycle.
- R8: A grant sets busy_o at the next rising edge and restarts the count. busy_o then falls timeout_i edges after the grant edge.
- R9: A request while busy_o is 1 is ignored. acq_grant_o stays 0 and the busy timing does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous to clk_i |
| timeout_i | input | 16 | Inactivity timeout in cycles; 0 means 65536 |
| acq_req_i | input | 1 | Local master asks for the bus |
| acq_grant_o | output | 1 | Request granted in this cycle |
| busy_o | output | 1 | Bus is busy (1) or idle (0) |
| idle_entry_o | output | 1 | One-cycle strobe on each busy-to-idle transition |

## Verification
The bench drives random clock-line gaps around the timeout boundary: a gap of exactly the timeout must keep the bus busy, and a gap one longer must release it. A design with an off-by-one counter, or one that lets the overflow win over a coinciding restart, goes idle one cycle early. A timeout of zero is run in full. A design that treats zero literally goes idle at once or never. Requests are issued while the bus is busy, and in the one cycle in which a clock transition is seen while idle. A design that grants in either case gives two masters the bus at the same time.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} bus_state_e;
endpackage

// File: rtl/scl_edge_det.sv
module scl_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else if (g == 0) sync_q[g] <= scl_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic [TW-1:0] cnt_o,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last_val;

  // limit 0 wraps to all ones: a full 2**TW cycle period
  assign last_val = limit_i - TW'(1);
  assign expire_o = run_i && !restart_i && (cnt_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + TW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bus_idle_monitor.sv
module bus_idle_monitor #(
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          acq_req_i,
  output logic          acq_grant_o,
  output logic          busy_o,
  output logic          idle_entry_o
);
  import bus_mon_pkg::*;

  bus_state_e    state_q, state_d;
  logic          scl_edge;
  logic          restart;
  logic          expire;
  logic          grant;
  logic [TW-1:0] cnt;
  logic          idle_entry_q;

  scl_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .edge_o(scl_edge)
  );

  idle_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .run_i    (state_q == ST_BUSY),
    .limit_i  (timeout_i),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  // another master's clock activity in this cycle beats a local request
  assign grant   = acq_req_i && (state_q == ST_IDLE) && !scl_edge;
  assign restart = scl_edge || grant;

  always_comb begin
    state_d = state_q;
    if (restart)     state_d = ST_BUSY;
    else if (expire) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_BUSY;
      idle_entry_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      idle_entry_q <= expire;
    end
  end

  assign acq_grant_o  = grant;
  assign busy_o       = (state_q == ST_BUSY);
  assign idle_entry_o = idle_entry_q;
endmodule

module bus_idle_monitor_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          idle_entry_i,
  input logic          grant_i,
  input logic          req_i,
  input logic          scl_edge_i,
  input logic [TW-1:0] cnt_i,
  input logic [TW-1:0] timeout_i
);
  p_edge_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_edge_i |=> busy_i && (cnt_i == '0));

  // R3: a zero timeout wraps to all ones here
  p_timeout_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($past(cnt_i) == $past(timeout_i) - TW'(1)));

  p_pulse_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_entry_i |-> $fell(busy_i));

  p_fall_has_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> idle_entry_i);

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !scl_edge_i && !grant_i) |=> !busy_i);

  p_grant_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (req_i && !busy_i && !scl_edge_i));

  p_grant_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> busy_i && (cnt_i == '0));

  p_busy_no_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !grant_i);
endmodule

bind bus_idle_monitor bus_idle_monitor_chk #(.TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_o),
  .idle_entry_i(idle_entry_o),
  .grant_i     (acq_grant_o),
  .req_i       (acq_req_i),
  .scl_edge_i  (scl_edge),
  .cnt_i       (cnt),
  .timeout_i   (timeout_i)
);

// File: tb/tb_bus_idle_monitor.sv
`timescale 1ns/1ps
module tb_bus_idle_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_i = 1'b1;
  logic [15:0] timeout_i = 16'd5;
  logic        acq_req_i = 1'b0;
  logic        acq_grant_o, busy_o, idle_entry_o;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit done = 0;

  // reference model state
  bit       m_busy = 1;
  bit       m_pulse = 0;
  int       m_since = 0;
  bit [2:0] hist = '0;
  bit       tog_now = 0;
  string    tag = "R4";

  always #10 clk_i = ~clk_i;

  bus_idle_monitor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .timeout_i(timeout_i),
    .acq_req_i(acq_req_i), .acq_grant_o(acq_grant_o), .busy_o(busy_o),
    .idle_entry_o(idle_entry_o)
  );

  function automatic int lim_of(logic [15:0] t);
    return (t == 16'd0) ? 65536 : int'(t);
  endfunction

  task automatic chk(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", t, what, act, exp, edges);
    end
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic cycle();
    bit exp_grant;
    #1;
    exp_grant = acq_req_i && !m_busy && !hist[1];
    chk(acq_grant_o == exp_grant, exp_grant ? "R7" : (m_busy ? "R9" : "R7"),
        "grant", int'(acq_grant_o), int'(exp_grant));
    @(posedge clk_i);
    edges++;
    hist = {hist[1:0], tog_now};
    tog_now = 0;
    m_pulse = 0;
    if (hist[2] || exp_grant) begin
      m_busy = 1; m_since = 0;
    end else if (m_busy) begin
      m_since++;
      if (m_since == lim_of(timeout_i)) begin m_busy = 0; m_pulse = 1; end
    end
    @(negedge clk_i);
    chk(busy_o == m_busy, tag, "busy", int'(busy_o), int'(m_busy));
    chk(idle_entry_o == m_pulse, "R5", "idle_entry", int'(idle_entry_o), int'(m_pulse));
  endtask

  task automatic toggle_scl();
    scl_i = ~scl_i;
    tog_now = 1;
  endtask

  task automatic run_idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    // R4: reset state
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b1, "R4", "busy in reset", int'(busy_o), 1);
    chk(idle_entry_o == 1'b0, "R4", "idle_entry in reset", int'(idle_entry_o), 0);
    chk(acq_grant_o == 1'b0, "R4", "grant in reset", int'(acq_grant_o), 0);
    rst_ni = 1'b1;
    tag = "R4";
    run_idle(7);

    // R6: activity while idle sets busy
    tag = "R6";
    toggle_scl();
    run_idle(3);
    run_idle(7);

    // R1/R2: random gaps around the timeout, several timeouts
    for (int grp = 0; grp < 6; grp++) begin
      timeout_i = 16'(1 + $urandom_range(0, 11));
      tag = "R2";
      for (int k = 0; k < 25; k++) begin
        int g;
        int t = lim_of(timeout_i);
        case ($urandom_range(0, 3))
          0: g = t;
          1: g = t + 1;
          default: g = 1 + $urandom_range(0, 2 * t + 3);
        endcase
        tag = (g <= t) ? "R1" : "R2";
        toggle_scl();
        run_idle(g);
      end
      tag = "R2";
      run_idle(lim_of(timeout_i) + 4);
    end

    // R7: request on the cycle an edge is seen while idle
    timeout_i = 16'd6;
    tag = "R7";
    toggle_scl();
    cycle();
    cycle();
    acq_req_i = 1'b1;
    cycle();
    acq_req_i = 1'b0;
    run_idle(10);

    // R7/R8: grant while idle, then timeout from grant edge
    tag = "R8";
    acq_req_i = 1'b1;
    cycle();
    acq_req_i = 1'b0;
    run_idle(9);

    // R9: requests while busy are ignored
    tag = "R9";
    toggle_scl();
    cycle(); cycle(); cycle();
    for (int i = 0; i < 5; i++) begin
      acq_req_i = 1'b1;
      cycle();
    end
    acq_req_i = 1'b0;
    run_idle(6);

    // random requests mixed with activity
    tag = "R7";
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 4) == 0) toggle_scl();
      acq_req_i = ($urandom_range(0, 2) == 0);
      cycle();
    end
    acq_req_i = 1'b0;
    run_idle(10);

    // R3: zero timeout means 65536
    timeout_i = 16'd0;
    tag = "R3";
    toggle_scl();
    run_idle(65536 + 6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule